// File: doc/BRIEF.md
# Multi-channel DAC command decoder

This block sits behind a byte-serial link whose framing has already been recovered. It receives framed bytes, builds 24-bit command words from them and keeps the register state for eight converter channels. Each channel has two registers. The holding (input) register takes new codes. The active (output) register holds the code that drives the converter. Commands can load either register, load both, or move held codes into the active registers for one channel or for every channel.

Beside the per-channel registers, the block keeps a power-down mask, a clear-code selector, a load-mask and a reference enable. A command returns all of this state to its power-on values. A sticky short mode lets a host stream pairs of data bytes that reuse the last command byte, which cuts the traffic needed to refresh one channel quickly.

The code width is a parameter. At 16 bits the whole data field is the code. At 12 bits the code sits in the upper twelve bits of the field and the low four bits are ignored. All state is visible on output ports.

Top module: `dac_cmd_decoder`

## Requirements
- R1: A frame starts with a start pulse and ends with a stop pulse. Within a frame, byte 1 is the command byte and bytes 2 and 3 are the data field, high byte first. Bits 7:4 of the command byte are the command code and bits 3:0 are the channel address. The word executes after its third byte, and its effect shows at the ports two clock edges after that byte is sampled.
- R2: Address values 0 to 7 select channel A to H. Address 15 selects all eight channels. Addresses 8 to 14 select no channel.
- R3: Command 0 loads the code into the input register of each selected channel. Output registers do not change.
- R4: Command 1 copies the input register of each selected channel into its output register.
- R5: Command 2 loads the code into the selected input registers. In the same step, every channel's output register takes that channel's new input value.
- R6: Command 3 loads the code into both the input and output registers of each selected channel.
- R7: Commands 4, 5, 6 and 8 load control state and ignore the address. Command 4 sets the power-down mask to data bits 7:0. Command 5 sets the clear-code selector to data bits 1:0. Command 6 sets the load-mask to data bits 7:0. Command 8 sets the reference enable to data bit 0.
- R8: Command 7, and the reset input, set every input register, output register, mask, selector, the reference enable and the short-mode flag to zero.
- R9: Command 9 sets the short-mode flag to data bit 0. While the flag is 1, each further pair of bytes in the same frame runs as a data field with the frame's command byte.
- R10: The short-mode flag keeps its value across frames. Every frame still starts with a full three-byte word.
- R11: A stop pulse drops any partial word. Bytes that arrive outside a frame are ignored.
- R12: Commands 10 to 15 leave every register unchanged.
- R13: With the code width set to 12, the stored code is data bits 15:4 and data bits 3:0 have no effect.
- R14: While short mode is off, bytes after the first word of a frame are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Start-of-frame pulse |
| frame_stop | input | 1 | End-of-frame pulse |
| byte_valid | input | 1 | Qualifies byte_data for one cycle |
| byte_data | input | 8 | Received byte |
| in_codes | output | NCH*CODE_W | Input registers, channel 0 in the low bits |
| out_codes | output | NCH*CODE_W | Output registers, channel 0 in the low bits |
| pd_mask | output | NCH | Power-down mask |
| clr_sel | output | 2 | Clear-code selector |
| load_mask | output | NCH | Load-mask register |
| ref_on | output | 1 | Reference enable |
| short_mode | output | 1 | Short two-byte mode flag |

## Verification
The bench targets the cases where the two register levels drift apart. One case is a software load that must also carry channels that had no new write. A decoder that moved only the addressed channel would leave stale active codes on the other seven. Broadcast and out-of-range addresses are driven with data that would show a mis-decode, and reserved commands are driven with all-ones data so that any write becomes visible. Short mode is tested within a frame, across frames and after it is cleared. Truncated frames and stray bytes are also sent, because a byte counter that is not cleared at a boundary corrupts every word that follows.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;

    localparam int CMD_W   = 4;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 16;
    localparam int WORD_W  = CMD_W + ADDR_W + DATA_W;
    localparam logic [ADDR_W-1:0] ADDR_ALL = 4'hF;

    typedef enum logic [CMD_W-1:0] {
        CMD_WR_IN      = 4'd0,
        CMD_UPD        = 4'd1,
        CMD_WR_UPD_ALL = 4'd2,
        CMD_WR_BOTH    = 4'd3,
        CMD_PWR        = 4'd4,
        CMD_CLR        = 4'd5,
        CMD_LOADMASK   = 4'd6,
        CMD_RESET      = 4'd7,
        CMD_REF        = 4'd8,
        CMD_MULTI      = 4'd9
    } dac_cmd_e;

    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } dac_word_t;

    function automatic logic is_reserved(input logic [CMD_W-1:0] c);
        return c >= 4'd10;
    endfunction

    function automatic logic chan_hit(input logic [ADDR_W-1:0] a, input int idx);
        return (a == ADDR_ALL) || (a == idx[ADDR_W-1:0]);
    endfunction

endpackage

// File: rtl/dac_word_assembler.sv
module dac_word_assembler
    import dac_cmd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      frame_start,
    input  logic      frame_stop,
    input  logic      byte_valid,
    input  logic [7:0] byte_data,
    input  logic      short_mode,
    output logic      word_valid,
    output dac_word_t word
);

    logic       in_frame;
    logic       have_cmd;
    logic [1:0] cnt;
    logic [7:0] cmd_q;
    logic [7:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame   <= 1'b0;
            have_cmd   <= 1'b0;
            cnt        <= 2'd0;
            cmd_q      <= 8'd0;
            hi_q       <= 8'd0;
            word_valid <= 1'b0;
            word       <= '0;
        end else begin
            word_valid <= 1'b0;
            if (frame_start || frame_stop) begin
                in_frame <= frame_start;
                have_cmd <= 1'b0;
                cnt      <= 2'd0;
            end else if (byte_valid && in_frame) begin
                if (!have_cmd) begin
                    case (cnt)
                        2'd0: begin
                            cmd_q <= byte_data;
                            cnt   <= 2'd1;
                        end
                        2'd1: begin
                            hi_q <= byte_data;
                            cnt  <= 2'd2;
                        end
                        default: begin
                            word       <= {cmd_q, hi_q, byte_data};
                            word_valid <= 1'b1;
                            have_cmd   <= 1'b1;
                            cnt        <= 2'd0;
                        end
                    endcase
                end else if (short_mode) begin
                    if (cnt == 2'd0) begin
                        hi_q <= byte_data;
                        cnt  <= 2'd1;
                    end else begin
                        word       <= {cmd_q, hi_q, byte_data};
                        word_valid <= 1'b1;
                        cnt        <= 2'd0;
                    end
                end
            end
        end
    end

    // R11: a stop boundary never lets a word through on the next cycle
    a_r11_stop_discards: assert property (@(posedge clk) disable iff (rst)
        frame_stop |=> !word_valid);

    // R1: the byte counter never reaches an unused value
    a_r1_count_range: assert property (@(posedge clk) disable iff (rst)
        cnt != 2'd3);

    // R9: even short words need two bytes, so words never come back to back
    a_r9_word_spacing: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);

endmodule

// File: rtl/dac_ctrl_regs.sv
module dac_ctrl_regs
    import dac_cmd_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           word_valid,
    input  dac_word_t      word,
    output logic [NCH-1:0] pd_mask,
    output logic [1:0]     clr_sel,
    output logic [NCH-1:0] load_mask,
    output logic           ref_on,
    output logic           short_mode
);

    always_ff @(posedge clk) begin
        if (rst || (word_valid && word.cmd == CMD_RESET)) begin
            pd_mask    <= '0;
            clr_sel    <= 2'd0;
            load_mask  <= '0;
            ref_on     <= 1'b0;
            short_mode <= 1'b0;
        end else if (word_valid) begin
            case (word.cmd)
                CMD_PWR:      pd_mask    <= word.data[NCH-1:0];
                CMD_CLR:      clr_sel    <= word.data[1:0];
                CMD_LOADMASK: load_mask  <= word.data[NCH-1:0];
                CMD_REF:      ref_on     <= word.data[0];
                CMD_MULTI:    short_mode <= word.data[0];
                default: ;
            endcase
        end
    end

    // R8: a reset command clears all control state
    a_r8_reset_clears: assert property (@(posedge clk) disable iff (rst)
        (word_valid && word.cmd == CMD_RESET) |=>
        (pd_mask == '0 && load_mask == '0 && clr_sel == 2'd0 && !ref_on && !short_mode));

    // R12: reserved commands keep control state
    a_r12_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
        (word_valid && is_reserved(word.cmd)) |=>
        ($stable(pd_mask) && $stable(load_mask) && $stable(clr_sel) &&
         $stable(ref_on) && $stable(short_mode)));

    // R9: the short-mode flag follows data bit 0 of command 9
    a_r9_mode_load: assert property (@(posedge clk) disable iff (rst)
        (word_valid && word.cmd == CMD_MULTI) |=> (short_mode == $past(word.data[0])));

endmodule

// File: rtl/dac_channel_slot.sv
module dac_channel_slot
    import dac_cmd_pkg::*;
#(
    parameter int CODE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_valid,
    input  logic [CMD_W-1:0]  cmd,
    input  logic              hit,
    input  logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] in_q,
    output logic [CODE_W-1:0] out_q
);

    always_ff @(posedge clk) begin
        if (rst || (word_valid && cmd == CMD_RESET)) begin
            in_q  <= '0;
            out_q <= '0;
        end else if (word_valid) begin
            case (cmd)
                CMD_WR_IN: if (hit) in_q <= code;
                CMD_UPD:   if (hit) out_q <= in_q;
                CMD_WR_UPD_ALL: begin
                    if (hit) begin
                        in_q  <= code;
                        out_q <= code;
                    end else begin
                        out_q <= in_q;
                    end
                end
                CMD_WR_BOTH: if (hit) begin
                    in_q  <= code;
                    out_q <= code;
                end
                default: ;
            endcase
        end
    end

    // R3: an input write never moves the output register
    a_r3_input_only: assert property (@(posedge clk) disable iff (rst)
        (word_valid && cmd == CMD_WR_IN) |=> $stable(out_q));

    // R4: an update copies the held value
    a_r4_update_copy: assert property (@(posedge clk) disable iff (rst)
        (word_valid && cmd == CMD_UPD && hit) |=> (out_q == $past(in_q)));

    // R5: after a software load both levels agree on every channel
    a_r5_levels_agree: assert property (@(posedge clk) disable iff (rst)
        (word_valid && cmd == CMD_WR_UPD_ALL) |=> (out_q == in_q));

    // R6: write-both leaves the two levels holding the new code
    a_r6_both_code: assert property (@(posedge clk) disable iff (rst)
        (word_valid && cmd == CMD_WR_BOTH && hit) |=> (out_q == $past(code) && in_q == $past(code)));

    // R12: reserved commands keep both levels
    a_r12_slot_hold: assert property (@(posedge clk) disable iff (rst)
        (word_valid && is_reserved(cmd)) |=> ($stable(in_q) && $stable(out_q)));

endmodule

// File: rtl/dac_channel_bank.sv
module dac_channel_bank
    import dac_cmd_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int CODE_W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       word_valid,
    input  dac_word_t                  word,
    output logic [NCH-1:0][CODE_W-1:0] in_arr,
    output logic [NCH-1:0][CODE_W-1:0] out_arr
);

    localparam int CODE_MSB = DATA_W - 1;

    logic [CODE_W-1:0] code;
    assign code = word.data[CODE_MSB -: CODE_W];

    for (genvar i = 0; i < NCH; i++) begin : g_slot
        logic hit;
        assign hit = chan_hit(word.addr, i);

        dac_channel_slot #(.CODE_W(CODE_W)) u_slot (
            .clk        (clk),
            .rst        (rst),
            .word_valid (word_valid),
            .cmd        (word.cmd),
            .hit        (hit),
            .code       (code),
            .in_q       (in_arr[i]),
            .out_q      (out_arr[i])
        );
    end

    // R2: an address outside 0..NCH-1 other than the broadcast value writes nothing
    a_r2_no_target: assert property (@(posedge clk) disable iff (rst)
        (word_valid && word.addr != ADDR_ALL && word.addr >= ADDR_W'(NCH) &&
         (word.cmd == CMD_WR_IN || word.cmd == CMD_WR_BOTH)) |=>
        ($stable(in_arr) && $stable(out_arr)));

endmodule

// File: rtl/dac_cmd_decoder.sv
module dac_cmd_decoder
    import dac_cmd_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int CODE_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    frame_start,
    input  logic                    frame_stop,
    input  logic                    byte_valid,
    input  logic [7:0]              byte_data,
    output logic [NCH*CODE_W-1:0]   in_codes,
    output logic [NCH*CODE_W-1:0]   out_codes,
    output logic [NCH-1:0]          pd_mask,
    output logic [1:0]              clr_sel,
    output logic [NCH-1:0]          load_mask,
    output logic                    ref_on,
    output logic                    short_mode
);

    logic                       word_valid;
    dac_word_t                  word;
    logic [NCH-1:0][CODE_W-1:0] in_arr;
    logic [NCH-1:0][CODE_W-1:0] out_arr;

    dac_word_assembler u_asm (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .frame_stop  (frame_stop),
        .byte_valid  (byte_valid),
        .byte_data   (byte_data),
        .short_mode  (short_mode),
        .word_valid  (word_valid),
        .word        (word)
    );

    dac_ctrl_regs #(.NCH(NCH)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .word_valid (word_valid),
        .word       (word),
        .pd_mask    (pd_mask),
        .clr_sel    (clr_sel),
        .load_mask  (load_mask),
        .ref_on     (ref_on),
        .short_mode (short_mode)
    );

    dac_channel_bank #(.NCH(NCH), .CODE_W(CODE_W)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .word_valid (word_valid),
        .word       (word),
        .in_arr     (in_arr),
        .out_arr    (out_arr)
    );

    assign in_codes  = in_arr;
    assign out_codes = out_arr;

endmodule

// File: tb/dac_cmd_decoder_bench.sv
module dac_cmd_decoder_bench;

    localparam int NCH = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst = 1'b1;
    logic       frame_start = 1'b0;
    logic       frame_stop = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = 8'd0;

    logic [NCH*16-1:0] in_w, out_w;
    logic [NCH*12-1:0] in_n, out_n;
    logic [NCH-1:0]    pd_w, lm_w, pd_n, lm_n;
    logic [1:0]        clr_w, clr_n;
    logic              ref_w, sh_w, ref_n, sh_n;

    dac_cmd_decoder #(.NCH(NCH), .CODE_W(16)) u_dac_cmd_decoder (
        .clk(clk), .rst(rst), .frame_start(frame_start), .frame_stop(frame_stop),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .in_codes(in_w), .out_codes(out_w), .pd_mask(pd_w), .clr_sel(clr_w),
        .load_mask(lm_w), .ref_on(ref_w), .short_mode(sh_w));

    dac_cmd_decoder #(.NCH(NCH), .CODE_W(12)) u_dac_cmd_decoder_n12 (
        .clk(clk), .rst(rst), .frame_start(frame_start), .frame_stop(frame_stop),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .in_codes(in_n), .out_codes(out_n), .pd_mask(pd_n), .clr_sel(clr_n),
        .load_mask(lm_n), .ref_on(ref_n), .short_mode(sh_n));

    int n_checks = 0;
    int n_fail = 0;

    logic [15:0] m_in  [NCH];
    logic [15:0] m_out [NCH];
    logic [7:0]  m_pd, m_lm;
    logic [1:0]  m_clr;
    logic        m_ref, m_sh;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < NCH; i++) begin
            chk({tag, " in"},  32'(in_w[i*16 +: 16]),  32'(m_in[i]));
            chk({tag, " out"}, 32'(out_w[i*16 +: 16]), 32'(m_out[i]));
            chk({tag, " R13 out12"}, 32'(out_n[i*12 +: 12]), 32'(m_out[i][15:4]));
        end
        chk({tag, " pd"},    32'(pd_w),  32'(m_pd));
        chk({tag, " clr"},   32'(clr_w), 32'(m_clr));
        chk({tag, " lmask"}, 32'(lm_w),  32'(m_lm));
        chk({tag, " ref"},   32'(ref_w), 32'(m_ref));
        chk({tag, " short"}, 32'(sh_w),  32'(m_sh));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
        idle(1);
    endtask

    task automatic pulse_stop();
        @(negedge clk) frame_stop = 1'b1;
        @(negedge clk) frame_stop = 1'b0;
        idle(2);
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_data  = b;
        @(negedge clk);
        byte_valid = 1'b0;
        idle(2);
    endtask

    task automatic send_word(input logic [3:0] cmd, input logic [3:0] addr, input logic [15:0] data);
        pulse_start();
        send_byte({cmd, addr});
        send_byte(data[15:8]);
        send_byte(data[7:0]);
        pulse_stop();
    endtask

    task automatic set_all(input logic [15:0] v);
        for (int i = 0; i < NCH; i++) begin
            m_in[i] = v;
            m_out[i] = v;
        end
    endtask

    task automatic t_reset_state();
        set_all(16'h0);
        m_pd = 0; m_lm = 0; m_clr = 0; m_ref = 0; m_sh = 0;
        check_all("R8 reset state");
    endtask

    task automatic t_input_then_update();
        send_word(4'd0, 4'd2, 16'h1234);
        m_in[2] = 16'h1234;
        check_all("R1 R3 input write");
        send_word(4'd1, 4'd2, 16'h0000);
        m_out[2] = 16'h1234;
        check_all("R4 update");
    endtask

    task automatic t_broadcast_and_bad_addr();
        send_word(4'd3, 4'hF, 16'hABCD);
        set_all(16'hABCD);
        check_all("R6 R2 broadcast both");
        send_word(4'd3, 4'd9, 16'h0F0F);
        send_word(4'd0, 4'd8, 16'h0F0F);
        check_all("R2 no-target address");
    endtask

    task automatic t_software_load();
        send_word(4'd0, 4'd0, 16'h1111);
        m_in[0] = 16'h1111;
        check_all("R3 held only");
        send_word(4'd2, 4'd5, 16'h5555);
        m_in[5] = 16'h5555;
        for (int i = 0; i < NCH; i++) m_out[i] = m_in[i];
        check_all("R5 software load");
    endtask

    task automatic t_ctrl_regs();
        send_word(4'd4, 4'd3, 16'h00A5); m_pd = 8'hA5;
        send_word(4'd5, 4'd0, 16'h0002); m_clr = 2'd2;
        send_word(4'd6, 4'd1, 16'h003C); m_lm = 8'h3C;
        send_word(4'd8, 4'd0, 16'h0001); m_ref = 1'b1;
        check_all("R7 control loads");
    endtask

    task automatic t_reserved();
        for (int c = 10; c < 16; c++) send_word(4'(c), 4'hF, 16'hFFFF);
        check_all("R12 reserved");
    endtask

    task automatic t_partial_and_stray();
        pulse_start();
        send_byte(8'h3F);
        send_byte(8'h00);
        pulse_stop();
        send_byte(8'h3F);
        send_byte(8'h00);
        send_byte(8'h00);
        check_all("R11 partial and stray");
    endtask

    task automatic t_normal_extra();
        pulse_start();
        send_byte(8'h31); send_byte(8'h01); send_byte(8'h01);
        send_byte(8'h22); send_byte(8'h22); send_byte(8'h22);
        pulse_stop();
        m_in[1] = 16'h0101; m_out[1] = 16'h0101;
        check_all("R14 extra bytes");
    endtask

    task automatic t_short_mode();
        send_word(4'd9, 4'd0, 16'h0001);
        m_sh = 1'b1;
        check_all("R9 enter short");
        pulse_start();
        send_byte(8'h34); send_byte(8'h44); send_byte(8'h44);
        send_byte(8'h45); send_byte(8'h45);
        m_in[4] = 16'h4545; m_out[4] = 16'h4545;
        check_all("R9 first pair");
        send_byte(8'h46); send_byte(8'h46);
        pulse_stop();
        m_in[4] = 16'h4646; m_out[4] = 16'h4646;
        check_all("R9 second pair");
        pulse_start();
        send_byte(8'h06); send_byte(8'h60); send_byte(8'h00);
        send_byte(8'h60); send_byte(8'h01);
        send_byte(8'h77);
        pulse_stop();
        m_in[6] = 16'h6001;
        check_all("R10 persists, R11 lone byte");
        send_word(4'd9, 4'd0, 16'h0000);
        m_sh = 1'b0;
        pulse_start();
        send_byte(8'h34); send_byte(8'h10); send_byte(8'h00);
        send_byte(8'h20); send_byte(8'h00);
        pulse_stop();
        m_in[4] = 16'h1000; m_out[4] = 16'h1000;
        check_all("R9 exit, R14 pair ignored");
    endtask

    task automatic t_reset_cmd();
        send_word(4'd9, 4'd0, 16'h0001);
        m_sh = 1'b1;
        check_all("R8 pre-reset");
        send_word(4'd7, 4'd0, 16'h0000);
        set_all(16'h0);
        m_pd = 0; m_lm = 0; m_clr = 0; m_ref = 0; m_sh = 0;
        check_all("R8 reset command");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(2);
        t_reset_state();
        t_input_then_update();
        t_broadcast_and_bad_addr();
        t_software_load();
        t_ctrl_regs();
        t_reserved();
        t_partial_and_stray();
        t_normal_extra();
        t_short_mode();
        t_reset_cmd();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule